// File: doc/BRIEF.md
# Discontinuous Space-Vector PWM Leg Pattern Generator

This block converts a two-axis voltage reference (signed alpha and beta samples) into the on/off states of three inverter legs using a five-segment discontinuous space-vector scheme. It uses no angle or trigonometric computation to find the sector. It compares beta against zero and against plus and minus root-three times alpha. From the sector it forms two thresholds: the first active-vector duration, and the sum of both active durations. Each duration is scaled by a gain input that folds in the carrier half period and the DC-link voltage. Both thresholds are then compared against a shared triangle carrier.

In every carrier period one leg stays clamped. It is held high in sectors 1, 3 and 5, so only the all-ones null vector appears there. It is held low in sectors 2, 4 and 6, so only the all-zeros null vector appears. The two other legs switch once on the way up and once on the way down, which gives the symmetric five-state order first active, second active, null, second active, first active. The sector and thresholds are sampled only when the carrier is at its minimum, so a period is never disturbed halfway through. The carrier source, the reference generator, dead-time insertion and gate drivers sit outside this block.

Top module: `svm_dpwm_core`

## Requirements
- R1: After reset, sector reads 0 and all three legs read 0. They stay so until the first carrier strobe at the carrier minimum (224). While the sector is 0, every leg is 0.
- R2: The sector is coded 1 to 6 from three bits (beta>0, beta>r, beta>-r). Here r = floor(alpha*7094/4096) and all comparisons are strict and signed. The codes are 101 for 1, 111 for 2, 110 for 3, 010 for 4, 000 for 5 and 001 for 6, and the two impossible codes give sector 1.
- R3: The sector and both thresholds are taken from the present inputs only in a strobe cycle whose carrier equals 224. Reference or gain changes at any other time have no effect until the next such strobe.
- R4: The legs are updated only on the clock edge that ends a strobe cycle, from that cycle's carrier. In cycles without a strobe they hold.
- R5: With s = floor(beta*2365/4096), m = alpha-s, p = alpha+s and q = 2s, the pair (first value, sum value) per sector is: 1:(m,p), 2:(p,q), 3:(q,-m), 4:(-m,-p), 5:(-p,-q), 6:(-q,m).
- R6: Each threshold is 224 + floor(value*gain/4096), saturated to the range 224 to 352. Overmodulation or a zero gain therefore never wraps around.
- R7: In odd sectors the clamped leg is 1, and each other leg is 1 exactly when carrier > its threshold (strictly, so equality gives 0).
- R8: In even sectors the clamped leg is 0, and each other leg is 1 exactly when carrier < its threshold (strictly).
- R9: The leg roles (clamped, first threshold, sum threshold) are (a,b,c) in sectors 1 and 4, (c,a,b) in sectors 2 and 5, and (b,c,a) in sectors 3 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alpha_ref | input | 12 | Signed alpha-axis reference |
| beta_ref | input | 12 | Signed beta-axis reference |
| vdc_gain | input | 16 | Unsigned duration scale, 12 fractional bits |
| carrier | input | 9 | Triangle carrier sample, 224 to 352 |
| carrier_stb | input | 1 | Marks a cycle carrying a new carrier sample |
| leg_a | output | 1 | Leg A switching state |
| leg_b | output | 1 | Leg B switching state |
| leg_c | output | 1 | Leg C switching state |
| sector | output | 3 | Latched sector, 0 before first latch |

## Verification
One full triangle period is run at each of six reference angles, one in the middle of each sector. This separates the sector decode, the per-sector rotation of leg roles and the two comparison polarities. A reference swapped halfway through a period shows whether the latch waits for the carrier minimum. A gain of one half, a zero gain and a deep overmodulation case tell the scaling apart from both ends of the saturation. A reference that puts both thresholds exactly on a carrier sample exposes any non-strict comparison. Hold cycles between strobes run throughout.

// File: rtl/svm_dpwm_pkg.sv
// Shared types for the discontinuous space-vector leg generator.
// Assumes a three-bit sector code where 0 means "nothing latched yet".
package svm_dpwm_pkg;

    typedef enum logic [2:0] {
        SEC_NONE = 3'd0,
        SEC_1    = 3'd1,
        SEC_2    = 3'd2,
        SEC_3    = 3'd3,
        SEC_4    = 3'd4,
        SEC_5    = 3'd5,
        SEC_6    = 3'd6
    } sector_e;

    // Leg vector bit positions: [0]=leg A, [1]=leg B, [2]=leg C.
    localparam int LEG_N = 3;

endpackage

// File: rtl/svm_sector_detect.sv
// Sector finder: compares beta with zero and with +/- sqrt(3)*alpha.
// Assumes signed two's-complement inputs; sqrt(3) is a rounded unsigned
// constant with FRAC fractional bits, product floored by arithmetic shift.
module svm_sector_detect
    import svm_dpwm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int FRAC = 12
) (
    input  logic signed [DW-1:0] alpha,
    input  logic signed [DW-1:0] beta,
    output sector_e              sec
);

    localparam int PW    = DW + FRAC + 3;
    localparam int ROOT3 = $rtoi(1.7320508075688772 * (2.0 ** FRAC) + 0.5);
    localparam logic signed [PW-1:0] ROOT3_S = PW'(ROOT3);

    logic signed [PW-1:0] a_ext, b_ext, prod, r_val;
    logic                 c_pos, c_up, c_dn;

    // Scale alpha by sqrt(3) and derive the three comparison bits.
    always_comb begin
        a_ext = {{(PW-DW){alpha[DW-1]}}, alpha};
        b_ext = {{(PW-DW){beta[DW-1]}}, beta};
        prod  = a_ext * ROOT3_S;
        r_val = prod >>> FRAC;
        c_pos = b_ext > 0;
        c_up  = b_ext > r_val;
        c_dn  = b_ext > -r_val;
    end

    // Map the comparison pattern to a sector number.
    always_comb begin
        case ({c_pos, c_up, c_dn})
            3'b101:  sec = SEC_1;
            3'b111:  sec = SEC_2;
            3'b110:  sec = SEC_3;
            3'b010:  sec = SEC_4;
            3'b000:  sec = SEC_5;
            3'b001:  sec = SEC_6;
            default: sec = SEC_1;
        endcase
    end

endmodule

// File: rtl/svm_thresh_sat.sv
// Turns one signed duration value into a carrier-domain threshold:
// CMIN + floor(value*gain / 2^GSH), saturated to [CMIN, CMAX].
// Assumes gain is unsigned and CMAX fits in CW bits.
module svm_thresh_sat #(
    parameter int VW   = 27,
    parameter int GW   = 16,
    parameter int GSH  = 12,
    parameter int CW   = 9,
    parameter int CMIN = 224,
    parameter int CMAX = 352
) (
    input  logic signed [VW-1:0] value,
    input  logic        [GW-1:0] gain,
    output logic        [CW-1:0] thr
);

    localparam int PW = VW + GW + 2;
    localparam logic signed [PW-1:0] LO = PW'(CMIN);
    localparam logic signed [PW-1:0] HI = PW'(CMAX);

    logic signed [PW-1:0] prod, dur, lvl;

    // Scale, offset onto the carrier base and clamp to the carrier range.
    always_comb begin
        prod = $signed({{(PW-VW){value[VW-1]}}, value}) *
               $signed({{(PW-GW){1'b0}}, gain});
        dur  = prod >>> GSH;
        lvl  = dur + LO;
        if (lvl < LO)
            thr = CW'(CMIN);
        else if (lvl > HI)
            thr = CW'(CMAX);
        else
            thr = lvl[CW-1:0];
    end

endmodule

// File: rtl/svm_duration_calc.sv
// Computes the two thresholds for a sector: the first active duration
// and the sum of both active durations, each scaled and saturated.
// Assumes the sector input comes from the finder for the same sample.
module svm_duration_calc
    import svm_dpwm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int GW   = 16,
    parameter int FRAC = 12,
    parameter int GSH  = 12,
    parameter int CW   = 9,
    parameter int CMIN = 224,
    parameter int CMAX = 352
) (
    input  logic signed [DW-1:0] alpha,
    input  logic signed [DW-1:0] beta,
    input  logic        [GW-1:0] gain,
    input  sector_e              sec,
    output logic        [CW-1:0] th_first,
    output logic        [CW-1:0] th_sum
);

    localparam int VW   = DW + FRAC + 3;
    localparam int INV3 = $rtoi(0.5773502691896258 * (2.0 ** FRAC) + 0.5);
    localparam logic signed [VW-1:0] INV3_S = VW'(INV3);

    logic signed [VW-1:0] a_ext, b_ext, s_raw, s_val;
    logic signed [VW-1:0] m_val, p_val, q_val;
    logic signed [VW-1:0] sel_val [2];
    logic        [CW-1:0] thr_val [2];

    // Form the three base quantities alpha-s, alpha+s and 2s.
    always_comb begin
        a_ext = {{(VW-DW){alpha[DW-1]}}, alpha};
        b_ext = {{(VW-DW){beta[DW-1]}}, beta};
        s_raw = b_ext * INV3_S;
        s_val = s_raw >>> FRAC;
        m_val = a_ext - s_val;
        p_val = a_ext + s_val;
        q_val = s_val <<< 1;
    end

    // Pick the sector's first-duration and sum-duration quantities.
    always_comb begin
        case (sec)
            SEC_1:   begin sel_val[0] = m_val;  sel_val[1] = p_val;  end
            SEC_2:   begin sel_val[0] = p_val;  sel_val[1] = q_val;  end
            SEC_3:   begin sel_val[0] = q_val;  sel_val[1] = -m_val; end
            SEC_4:   begin sel_val[0] = -m_val; sel_val[1] = -p_val; end
            SEC_5:   begin sel_val[0] = -p_val; sel_val[1] = -q_val; end
            SEC_6:   begin sel_val[0] = -q_val; sel_val[1] = m_val;  end
            default: begin sel_val[0] = '0;     sel_val[1] = '0;     end
        endcase
    end

    for (genvar g = 0; g < 2; g++) begin : g_sat
        svm_thresh_sat #(
            .VW(VW), .GW(GW), .GSH(GSH), .CW(CW), .CMIN(CMIN), .CMAX(CMAX)
        ) u_sat (
            .value(sel_val[g]),
            .gain (gain),
            .thr  (thr_val[g])
        );
    end

    assign th_first = thr_val[0];
    assign th_sum   = thr_val[1];

endmodule

// File: rtl/svm_leg_compare.sv
// Carrier comparator and leg router. Odd sectors clamp one leg high and
// raise the others while the carrier is above their threshold; even
// sectors clamp one leg low and raise the others while it is below.
// Assumes sector 0 means idle: all legs low.
module svm_leg_compare
    import svm_dpwm_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic [CW-1:0]    carrier,
    input  logic [CW-1:0]    th_first,
    input  logic [CW-1:0]    th_sum,
    input  sector_e          sec,
    output logic [LEG_N-1:0] legs
);

    logic odd, hit_f, hit_s;

    // Compare the carrier with both thresholds using the sector's polarity.
    always_comb begin
        odd   = sec[0];
        hit_f = odd ? (carrier > th_first) : (carrier < th_first);
        hit_s = odd ? (carrier > th_sum)   : (carrier < th_sum);
    end

    // Route clamp and compare results onto legs by 60-degree rotation.
    always_comb begin
        case (sec)
            SEC_1, SEC_4: legs = {hit_s, hit_f, odd};
            SEC_2, SEC_5: legs = {odd, hit_s, hit_f};
            SEC_3, SEC_6: legs = {hit_f, odd, hit_s};
            default:      legs = '0;
        endcase
    end

endmodule

// File: rtl/svm_dpwm_core.sv
// Top of the discontinuous space-vector leg generator. Samples sector and
// thresholds at the carrier minimum and registers leg states on every
// carrier strobe. Assumes the carrier sweeps CMIN..CMAX and that the
// strobe marks each new carrier value.
module svm_dpwm_core
    import svm_dpwm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int GW   = 16,
    parameter int FRAC = 12,
    parameter int GSH  = 12,
    parameter int CW   = 9,
    parameter int CMIN = 224,
    parameter int CMAX = 352
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] alpha_ref,
    input  logic signed [DW-1:0] beta_ref,
    input  logic        [GW-1:0] vdc_gain,
    input  logic        [CW-1:0] carrier,
    input  logic                 carrier_stb,
    output logic                 leg_a,
    output logic                 leg_b,
    output logic                 leg_c,
    output logic        [2:0]    sector
);

    sector_e          sec_new, sec_q, sec_use;
    logic [CW-1:0]    thf_new, ths_new, thf_q, ths_q, thf_use, ths_use;
    logic [LEG_N-1:0] legs_nx, legs_q;
    logic             at_min;

    svm_sector_detect #(.DW(DW), .FRAC(FRAC)) u_sector (
        .alpha(alpha_ref),
        .beta (beta_ref),
        .sec  (sec_new)
    );

    svm_duration_calc #(
        .DW(DW), .GW(GW), .FRAC(FRAC), .GSH(GSH),
        .CW(CW), .CMIN(CMIN), .CMAX(CMAX)
    ) u_dur (
        .alpha   (alpha_ref),
        .beta    (beta_ref),
        .gain    (vdc_gain),
        .sec     (sec_new),
        .th_first(thf_new),
        .th_sum  (ths_new)
    );

    // Use freshly computed values at the carrier minimum, held ones otherwise.
    always_comb begin
        at_min  = carrier_stb && (carrier == CW'(CMIN));
        sec_use = at_min ? sec_new : sec_q;
        thf_use = at_min ? thf_new : thf_q;
        ths_use = at_min ? ths_new : ths_q;
    end

    svm_leg_compare #(.CW(CW)) u_cmp (
        .carrier (carrier),
        .th_first(thf_use),
        .th_sum  (ths_use),
        .sec     (sec_use),
        .legs    (legs_nx)
    );

    // Hold sector and thresholds for one carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= SEC_NONE;
            thf_q <= CW'(CMAX);
            ths_q <= CW'(CMAX);
        end else if (at_min) begin
            sec_q <= sec_new;
            thf_q <= thf_new;
            ths_q <= ths_new;
        end
    end

    // Register the leg states on every carrier sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            legs_q <= '0;
        else if (carrier_stb)
            legs_q <= legs_nx;
    end

    assign leg_a  = legs_q[0];
    assign leg_b  = legs_q[1];
    assign leg_c  = legs_q[2];
    assign sector = sec_q;

endmodule

// File: rtl/svm_dpwm_chk.sv
// Property checker for svm_dpwm_core, attached with bind below.
module svm_dpwm_chk #(
    parameter int CW   = 9,
    parameter int CMIN = 224
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] carrier,
    input logic          carrier_stb,
    input logic          leg_a,
    input logic          leg_b,
    input logic          leg_c,
    input logic [2:0]    sector
);

    // R1: nothing switches before a sector has been latched.
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sector == 3'd0) |-> ({leg_a, leg_b, leg_c} == 3'b000));

    // R3: sector moves only after a strobe at the carrier minimum.
    assert_sector_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(carrier_stb) && ($past(carrier) == CW'(CMIN))) |-> $stable(sector));

    // R4: legs hold through cycles without a strobe.
    assert_legs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(carrier_stb) |-> $stable({leg_a, leg_b, leg_c}));

    // R7 and R9: odd sectors keep their clamped leg high.
    assert_odd_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sector[0] |-> ((sector == 3'd1 && leg_a) || (sector == 3'd3 && leg_b) ||
                       (sector == 3'd5 && leg_c)));

    // R8 and R9: even sectors keep their clamped leg low.
    assert_even_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sector != 3'd0 && !sector[0]) |->
            ((sector == 3'd2 && !leg_c) || (sector == 3'd4 && !leg_a) ||
             (sector == 3'd6 && !leg_b)));

endmodule

bind svm_dpwm_core svm_dpwm_chk #(.CW(CW), .CMIN(CMIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier    (carrier),
    .carrier_stb(carrier_stb),
    .leg_a      (leg_a),
    .leg_b      (leg_b),
    .leg_c      (leg_c),
    .sector     (sector)
);

// File: tb/sim_svm_dpwm_core.sv
// Directed bench for svm_dpwm_core; one task per scenario.
module sim_svm_dpwm_core;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] alpha_ref = '0;
    logic signed [11:0] beta_ref = '0;
    logic        [15:0] vdc_gain = 16'd4096;
    logic        [8:0]  carrier = 9'd288;
    logic               carrier_stb = 1'b0;
    logic               leg_a, leg_b, leg_c;
    logic        [2:0]  sector;

    int total = 0;
    int bad   = 0;

    // Model state derived from the requirements.
    int cur_a = 0, cur_b = 0, cur_g = 4096;
    int m_sec = 0, m_thf = 352, m_ths = 352;
    int m_legs = 0;

    always #5 clk = ~clk;

    svm_dpwm_core u0 (
        .clk(clk), .rst_n(rst_n), .alpha_ref(alpha_ref), .beta_ref(beta_ref),
        .vdc_gain(vdc_gain), .carrier(carrier), .carrier_stb(carrier_stb),
        .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c), .sector(sector)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sec_of(input int a, input int b);
        int r = (a * 7094) >>> 12;
        bit [2:0] k = {b > 0, b > r, b > -r};
        case (k)
            3'b101: return 1;
            3'b111: return 2;
            3'b110: return 3;
            3'b010: return 4;
            3'b000: return 5;
            3'b001: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic int sat(input int v, input int g);
        int t = ((v * g) >>> 12) + 224;
        if (t < 224) return 224;
        if (t > 352) return 352;
        return t;
    endfunction

    // Model of one strobe: latch at minimum (R3), then compare (R7..R9).
    task automatic model_strobe(input int c);
        int s, m, p, q, vf, vs, hf, hs, odd;
        if (c == 224) begin
            m_sec = sec_of(cur_a, cur_b);
            s = (cur_b * 2365) >>> 12;
            m = cur_a - s; p = cur_a + s; q = 2 * s;
            case (m_sec)
                1: begin vf = m;  vs = p;  end
                2: begin vf = p;  vs = q;  end
                3: begin vf = q;  vs = -m; end
                4: begin vf = -m; vs = -p; end
                5: begin vf = -p; vs = -q; end
                default: begin vf = -q; vs = m; end
            endcase
            m_thf = sat(vf, cur_g);
            m_ths = sat(vs, cur_g);
        end
        if (m_sec == 0) begin
            m_legs = 0;
        end else begin
            odd = m_sec % 2;
            hf = odd ? (c > m_thf) : (c < m_thf);
            hs = odd ? (c > m_ths) : (c < m_ths);
            case (m_sec)
                1, 4: m_legs = odd + 2 * hf + 4 * hs;
                2, 5: m_legs = hf + 2 * hs + 4 * odd;
                default: m_legs = hs + 2 * odd + 4 * hf;
            endcase
        end
    endtask

    task automatic set_ref(input int a, input int b, input int g);
        cur_a = a; cur_b = b; cur_g = g;
        alpha_ref = 12'(a); beta_ref = 12'(b); vdc_gain = 16'(g);
    endtask

    // Drive one cycle, then compare outputs after the following edge.
    task automatic tick(input int c, input bit stb, input string req);
        int act, exp;
        carrier = 9'(c);
        carrier_stb = stb;
        if (stb) model_strobe(c);
        @(negedge clk);
        act = {sector, leg_c, leg_b, leg_a};
        exp = (m_sec << 3) | m_legs;
        check(act == exp, req, act, exp);
    endtask

    // One carrier period, 32 samples, each followed by a hold cycle (R4).
    task automatic run_period(input string req);
        for (int i = 0; i < 16; i++) begin
            tick(224 + 8 * i, 1'b1, req);
            tick(224 + 8 * i, 1'b0, "R4 hold");
        end
        for (int i = 0; i < 16; i++) begin
            tick(352 - 8 * i, 1'b1, req);
            tick(352 - 8 * i, 1'b0, "R4 hold");
        end
    endtask

    task automatic t_reset;
        check(sector == 3'd0, "R1 reset sector", sector, 0);
        check({leg_c, leg_b, leg_a} == 3'b000, "R1 reset legs", {leg_c, leg_b, leg_a}, 0);
        set_ref(35, 20, 4096);
        tick(288, 1'b1, "R1 strobe off minimum");
        tick(296, 1'b1, "R1 strobe off minimum");
        check(sector == 3'd0, "R1 still idle", sector, 0);
    endtask

    task automatic t_sectors;
        int av[6] = '{35, 0, -35, -35, 0, 35};
        int bv[6] = '{20, 40, 20, -20, -40, -20};
        for (int k = 0; k < 6; k++) begin
            set_ref(av[k], bv[k], 4096);
            run_period("R5 R7 R8 R9 pattern");
            check(sector == 3'(k + 1), "R2 sector decode", sector, k + 1);
        end
    endtask

    task automatic t_midchange;
        set_ref(35, 20, 4096);
        run_period("R3 setup");
        for (int i = 0; i < 6; i++) tick(224 + 8 * i, 1'b1, "R3 first half");
        set_ref(-35, -20, 4096);
        for (int i = 6; i < 16; i++) tick(224 + 8 * i, 1'b1, "R3 ignored change");
        check(sector == 3'd1, "R3 sector held", sector, 1);
        for (int i = 0; i < 16; i++) tick(352 - 8 * i, 1'b1, "R3 ignored change");
        tick(224, 1'b1, "R3 new latch");
        check(sector == 3'd4, "R3 latched at minimum", sector, 4);
    endtask

    task automatic t_gain;
        set_ref(35, 20, 2048);
        run_period("R6 half gain");
        set_ref(35, 20, 0);
        run_period("R6 zero gain");
        tick(232, 1'b1, "R6 zero gain");
        check({leg_c, leg_b, leg_a} == 3'b111, "R6 zero gain all high", {leg_c, leg_b, leg_a}, 7);
    endtask

    task automatic t_overmod;
        set_ref(2000, 1, 4096);
        run_period("R6 overmod odd");
        tick(352, 1'b1, "R6 overmod odd");
        check({leg_c, leg_b} == 2'b00, "R6 no wrap at peak", {leg_c, leg_b}, 0);
        set_ref(-2000, -1, 4096);
        run_period("R6 overmod even");
        tick(344, 1'b1, "R6 overmod even");
        check({leg_c, leg_b, leg_a} == 3'b110, "R6 saturated high", {leg_c, leg_b, leg_a}, 6);
    endtask

    task automatic t_equal;
        set_ref(32, 1, 4096);
        run_period("R7 equal thresholds");
        tick(224, 1'b1, "R7 equal");
        for (int i = 1; i <= 4; i++) tick(224 + 8 * i, 1'b1, "R7 equal");
        check({leg_c, leg_b, leg_a} == 3'b001, "R7 strict at 256", {leg_c, leg_b, leg_a}, 1);
        tick(264, 1'b1, "R7 equal");
        check({leg_c, leg_b, leg_a} == 3'b111, "R7 above 256", {leg_c, leg_b, leg_a}, 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_sectors;
        t_midchange;
        t_gain;
        t_overmod;
        t_equal;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule